// File: doc/BRIEF.md
# Right-Justified Stereo Serial Audio Receiver

This block turns a right-justified stereo serial audio stream into parallel samples. The bit clock, the word-select line and the data line come from outside the system clock domain. Each of them passes through a synchroniser into the system clock. The block then detects edges of the bit clock and of word-select from the synchronised copies. On every rising bit-clock edge, the data bit shifts into a 24-bit history register. When word-select toggles, the newest N bits of that history form the sample of the half-frame that has just ended.

In this format the last data bit of a sample is the one just before the word-select change. For that reason the capture happens at the end of a half-frame and not at its start. A two-bit input selects the word length N. The new length is picked up only where a left half-frame begins. The captured value is sign-extended to 24 bits and published with a one-cycle strobe for its channel. If a half-frame held too few bit clocks, the block raises a framing-error pulse instead of a strobe.

The system clock must run at least four times faster than the bit clock.

Top module: `rj_audio_rx`

## Requirements
- R1: While reset is held and directly after it, `left_data` and `right_data` read zero, and `left_valid`, `right_valid` and `frame_err` are low.
- R2: Data is sampled on rising bit-clock edges, most significant bit first. The sample is the last N bits received before the word-select transition.
- R3: The left channel is carried while word-select is high. At a high-to-low transition, `left_data` is loaded and `left_valid` pulses for one cycle. At a low-to-high transition, the right sample is published the same way on `right_data` and `right_valid`. The two strobes never occur in the same cycle.
- R4: `wlen_sel` selects the word length: 0 gives 16 bits, 1 gives 18, 2 gives 20 and 3 gives 24.
- R5: The captured N-bit value is sign-extended to 24 bits, with bit N-1 copied into the upper bits.
- R6: Bits that arrive earlier than the last N bits of a half-frame have no effect on the published sample.
- R7: `left_data` and `right_data` change only in a cycle where their strobe is high. They hold their value through framing errors.
- R8: If a half-frame ends with fewer than N rising bit-clock edges, `frame_err` pulses for one cycle and no strobe is given for that half-frame.
- R9: After reset, the first word-select transition only marks the start of a complete half-frame. It produces no strobe and no framing error.
- R10: `wlen_sel` is latched at each low-to-high word-select transition and applies to the left and right samples that follow. The right sample that ends at that same transition uses the previous length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_in | input | 1 | Serial bit clock, asynchronous |
| ws_in | input | 1 | Word select: high = left, low = right |
| sdata_in | input | 1 | Serial data, MSB first |
| wlen_sel | input | 2 | Word length code (16/18/20/24) |
| left_data | output | 24 | Last left sample, sign-extended |
| left_valid | output | 1 | One-cycle strobe for a new left sample |
| right_data | output | 24 | Last right sample, sign-extended |
| right_valid | output | 1 | One-cycle strobe for a new right sample |
| frame_err | output | 1 | One-cycle pulse for a short half-frame |

## Verification
The assertions check four things on every cycle:
- each strobe follows the word-select direction that belongs to its channel;
- the strobes and the error pulse are mutually exclusive;
- nothing is published before the receiver is armed;
- the sample outputs stay stable between strobes.

The value of each sample is left to the directed scenarios. Only those scenarios can show the right-justified window, the sign extension for each word length, the padding being ignored, the short half-frame and the deferred word-length change.

// File: rtl/rj_audio_rx.sv
module rj_audio_rx #(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bclk_in,
  input  logic        ws_in,
  input  logic        sdata_in,
  input  logic [1:0]  wlen_sel,
  output logic [23:0] left_data,
  output logic        left_valid,
  output logic [23:0] right_data,
  output logic        right_valid,
  output logic        frame_err
);
  localparam int DW      = 24;
  localparam int CNT_MAX = (1 << CNT_W) - 1;
  localparam int WARM_N  = SYNC_STAGES + 1;
  localparam int WARM_W  = $clog2(WARM_N + 1);

  logic [SYNC_STAGES-1:0] bclk_sy, ws_sy, sd_sy;
  logic                   bclk_d, ws_d, armed;
  logic [WARM_W-1:0]      warm;
  logic [DW-1:0]          shreg;
  logic [CNT_W-1:0]       bitcnt, need_n;
  logic [1:0]             wl_act;
  logic [DW-1:0]          cap;

  wire bclk_s    = bclk_sy[SYNC_STAGES-1];
  wire ws_s      = ws_sy[SYNC_STAGES-1];
  wire sd_s      = sd_sy[SYNC_STAGES-1];
  wire warm_done = (warm == WARM_W'(WARM_N));
  wire bclk_rise = bclk_s & ~bclk_d;
  wire ws_edge   = (ws_s ^ ws_d) & warm_done;
  wire short_hf  = bitcnt < need_n;

  always_comb begin
    case (wl_act)
      2'd0:    need_n = CNT_W'(16);
      2'd1:    need_n = CNT_W'(18);
      2'd2:    need_n = CNT_W'(20);
      default: need_n = CNT_W'(24);
    endcase
  end

  always_comb begin
    case (wl_act)
      2'd0:    cap = {{8{shreg[15]}}, shreg[15:0]};
      2'd1:    cap = {{6{shreg[17]}}, shreg[17:0]};
      2'd2:    cap = {{4{shreg[19]}}, shreg[19:0]};
      default: cap = shreg;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_sy     <= '0;
      ws_sy       <= '0;
      sd_sy       <= '0;
      bclk_d      <= 1'b0;
      ws_d        <= 1'b0;
      warm        <= '0;
      armed       <= 1'b0;
      shreg       <= '0;
      bitcnt      <= '0;
      wl_act      <= 2'd3;
      left_data   <= '0;
      right_data  <= '0;
      left_valid  <= 1'b0;
      right_valid <= 1'b0;
      frame_err   <= 1'b0;
    end else begin
      bclk_sy     <= {bclk_sy[SYNC_STAGES-2:0], bclk_in};
      ws_sy       <= {ws_sy[SYNC_STAGES-2:0], ws_in};
      sd_sy       <= {sd_sy[SYNC_STAGES-2:0], sdata_in};
      bclk_d      <= bclk_s;
      ws_d        <= ws_s;
      left_valid  <= 1'b0;
      right_valid <= 1'b0;
      frame_err   <= 1'b0;
      if (!warm_done) warm <= warm + WARM_W'(1);

      if (bclk_rise) shreg <= {shreg[DW-2:0], sd_s};

      if (ws_edge)
        bitcnt <= bclk_rise ? CNT_W'(1) : '0;
      else if (bclk_rise && bitcnt != CNT_W'(CNT_MAX))
        bitcnt <= bitcnt + CNT_W'(1);

      if (!armed || (ws_edge && ws_s)) wl_act <= wlen_sel;

      if (ws_edge) begin
        if (!armed) begin
          armed <= 1'b1;
        end else if (short_hf) begin
          frame_err <= 1'b1;
        end else if (ws_s) begin
          right_data  <= cap;
          right_valid <= 1'b1;
        end else begin
          left_data  <= cap;
          left_valid <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rj_audio_rx_chk.sv
module rj_audio_rx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ws_s,
  input logic        ws_d,
  input logic        armed,
  input logic        left_valid,
  input logic        right_valid,
  input logic        frame_err,
  input logic [23:0] left_data,
  input logic [23:0] right_data
);
  a_r3_left_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    left_valid |-> $past(ws_d && !ws_s));

  a_r3_right_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    right_valid |-> $past(!ws_d && ws_s));

  a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(left_valid && right_valid));

  a_r8_err_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> (!left_valid && !right_valid));

  a_r9_armed_first: assert property (@(posedge clk) disable iff (!rst_n)
    (left_valid || right_valid || frame_err) |-> $past(armed));

  a_r7_left_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !left_valid |-> $stable(left_data));

  a_r7_right_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !right_valid |-> $stable(right_data));
endmodule

bind rj_audio_rx rj_audio_rx_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .ws_s        (ws_s),
  .ws_d        (ws_d),
  .armed       (armed),
  .left_valid  (left_valid),
  .right_valid (right_valid),
  .frame_err   (frame_err),
  .left_data   (left_data),
  .right_data  (right_data)
);

// File: tb/rj_audio_rx_tb_top.sv
module rj_audio_rx_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk_in = 1'b0, ws_in = 1'b0, sdata_in = 1'b0;
  logic [1:0]  wlen_sel = 2'd3;
  logic [23:0] left_data, right_data;
  logic        left_valid, right_valid, frame_err;

  int tests = 0, fails = 0;
  int nl = 0, nr = 0, ne = 0;
  logic [23:0] last_l = '0, last_r = '0;
  logic [23:0] exp_r = '0, exp_l = '0;
  bit have_r = 0, done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rj_audio_rx dut_i (
    .clk(clk), .rst_n(rst_n), .bclk_in(bclk_in), .ws_in(ws_in),
    .sdata_in(sdata_in), .wlen_sel(wlen_sel),
    .left_data(left_data), .left_valid(left_valid),
    .right_data(right_data), .right_valid(right_valid),
    .frame_err(frame_err)
  );

  always @(negedge clk) if (rst_n) begin
    if (left_valid)  begin nl++; last_l = left_data;  end
    if (right_valid) begin nr++; last_r = right_data; end
    if (frame_err)   ne++;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int nbits(input logic [1:0] code);
    case (code)
      2'd0: return 16;
      2'd1: return 18;
      2'd2: return 20;
      default: return 24;
    endcase
  endfunction

  function automatic logic [23:0] sx(input logic [23:0] v, input int n);
    int s;
    s = int'({8'd0, v}) << (32 - n);
    s = s >>> (32 - n);
    return s[23:0];
  endfunction

  task automatic half(input logic lvl, input logic [23:0] val, input int n,
                      input int total, input logic pad);
    nl = 0; nr = 0; ne = 0;
    ws_in = lvl; bclk_in = 1'b0;
    if (total == 0) tick(8);
    for (int k = total - 1; k >= 0; k--) begin
      bclk_in = 1'b0;
      sdata_in = (k < n) ? val[k] : pad;
      tick(4);
      bclk_in = 1'b1;
      tick(4);
    end
  endtask

  task automatic check_prev_right();
    if (have_r) begin
      chk("R3 right strobe count", nr, 1);
      chk("R5 right sample", last_r, exp_r);
    end
  endtask

  task automatic t_reset();
    tick(2);
    chk("R1 left_data", left_data, 0);
    chk("R1 right_data", right_data, 0);
    chk("R1 strobes/err", {left_valid, right_valid, frame_err}, 0);
    rst_n = 1'b1;
    tick(1);
    chk("R1 strobes after release", {left_valid, right_valid, frame_err}, 0);
  endtask

  task automatic t_startup();
    wlen_sel = 2'd3;
    half(1'b0, 24'h0, 24, 20, 1'b0);
    chk("R9 nothing before first edge", nl + nr + ne, 0);
    half(1'b1, 24'h123456, 24, 24, 1'b0);
    chk("R9 first edge only arms", nl + nr + ne, 0);
    half(1'b0, 24'hABCDEF, 24, 24, 1'b1);
    chk("R3 left strobe count", nl, 1);
    chk("R2 left sample", last_l, sx(24'h123456, 24));
    exp_l = sx(24'h123456, 24);
    exp_r = sx(24'hABCDEF, 24);
    have_r = 1;
  endtask

  task automatic t_pair(input logic [1:0] code, input logic [23:0] lv,
                        input logic [23:0] rv, input int extra, input logic pad);
    int n;
    n = nbits(code);
    wlen_sel = code;
    half(1'b1, lv, n, n + extra, pad);
    check_prev_right();
    chk("R7 left holds during right strobe", left_data, exp_l);
    half(1'b0, rv, n, n + extra, pad);
    chk("R3 left strobe count", nl, 1);
    chk("R4 R5 R6 left sample", last_l, sx(lv, n));
    chk("R8 no error on full half-frame", ne, 0);
    chk("R7 right holds during left strobe", right_data, exp_r);
    exp_l = sx(lv, n);
    exp_r = sx(rv, n);
  endtask

  task automatic t_midchange();
    wlen_sel = 2'd3;
    half(1'b1, 24'hA5A5A5, 24, 24, 1'b0);
    check_prev_right();
    wlen_sel = 2'd0;
    half(1'b0, 24'h128000, 24, 24, 1'b0);
    chk("R10 left keeps latched length", last_l, sx(24'hA5A5A5, 24));
    exp_l = sx(24'hA5A5A5, 24);
    exp_r = sx(24'h128000, 24);
  endtask

  task automatic t_short();
    wlen_sel = 2'd3;
    half(1'b1, 24'h000ABC, 24, 10, 1'b0);
    check_prev_right();
    half(1'b0, 24'h00F00D, 24, 24, 1'b0);
    chk("R8 error pulse on short half-frame", ne, 1);
    chk("R8 no strobe on short half-frame", nl, 0);
    chk("R7 left holds after error", left_data, exp_l);
    exp_r = sx(24'h00F00D, 24);
  endtask

  task automatic t_close();
    half(1'b1, 24'h0, 24, 0, 1'b0);
    check_prev_right();
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    t_reset();
    t_startup();
    t_pair(2'd3, 24'h7FFFFF, 24'h800000, 4, 1'b0);
    t_pair(2'd0, 24'h008001, 24'h007FFE, 8, 1'b1);
    t_pair(2'd1, 24'h020005, 24'h01FFFF, 6, 1'b1);
    t_pair(2'd2, 24'h080000, 24'h001234, 4, 1'b0);
    t_midchange();
    t_pair(2'd0, 24'h00C3C3, 24'h00FFFF, 2, 1'b0);
    t_short();
    t_pair(2'd3, 24'hFEDCBA, 24'h010203, 0, 1'b1);
    t_close();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule